// File: doc/BRIEF.md
# Handshaked Reset Sequencer for a Three-Domain Ethernet Core

This block sits beside an Ethernet core and owns its three active-low reset requests: one for the whole core, one for the transmit datapath and one for the receive datapath. Each reset has an active-low acknowledge coming back from the core. The acknowledge goes low once the domain is fully in reset. The core also returns two readiness levels: TX lanes stable and RX PCS ready. The sequencer drives a reset low, waits for the matching acknowledge, and releases the reset. It then waits until the domain reports readiness again before it declares the core usable.

System logic asks for a full, TX-only or RX-only reset with single-cycle pulses. Requests that arrive while a sequence is running are held and served afterwards, highest priority first. A pending full reset swallows any pending partial reset. At power-on the sequencer holds the full reset and runs the release sequence by itself. Every wait is bounded by a cycle limit that software sets. If the limit expires, a sticky error flag is set, the reset is let go, and the sequencer becomes idle again. All returning acknowledge and readiness levels pass through two-flop synchronizers before the control logic uses them.

Top module: `reset_handshake_seq`

## Requirements
- R1: While `arstN` is low, and after it rises, `coreRstN` is low, `txRstN` and `rxRstN` are high and `busy` is high. The full release sequence then runs to completion without any request.
- R2: At most one of `coreRstN`, `txRstN` and `rxRstN` is low at any time. As a result, `coreRstN` rises only while `txRstN` and `rxRstN` are both high.
- R3: A reset output rises only after its own acknowledge has been low for at least two consecutive cycles. The single exception is a release caused by a timeout.
- R4: A TX-only request drives only `txRstN` low. After `txAckN` goes low, `txRstN` is released. The sequence ends once `txAckN` and `txLanesStable` are both high.
- R5: An RX-only request drives only `rxRstN` low. After `rxAckN` goes low, `rxRstN` is released. The sequence ends once `rxAckN` and `rxPcsReady` are both high.
- R6: After a full reset is released, the sequencer accepts `txAckN` and `rxAckN` rising in any order and at any time relative to `coreAckN`. It finishes only when both acknowledges are high and both readiness inputs are high.
- R7: `trafficReady` is high only when the sequencer is idle and the synchronized `txLanesStable` and `rxPcsReady` are both high. It is low while the core has left full reset but a readiness input is still low.
- R8: Requests pending together are served in the order full, then TX, then RX.
- R9: A request pulse that arrives while `busy` is high is remembered. It is served after the current sequence ends.
- R10: When a full reset is taken, every pending TX or RX request is discarded. Neither `txRstN` nor `rxRstN` goes low for such a request.
- R11: If a wait lasts more than `timeoutLimit` cycles, `timeoutErr` is set and all reset outputs are high. `busy` then falls. `timeoutErr` stays set until `arstN` is asserted.
- R12: A request pulse takes effect on the second rising edge after the pulse: the reset output falls and `busy` rises. `busy` stays high while any reset output is low and until the affected domain reports readiness or a timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| arstN | input | 1 | Asynchronous active-low reset of the sequencer itself |
| reqFull | input | 1 | Single-cycle pulse requesting a full core reset |
| reqTx | input | 1 | Single-cycle pulse requesting a TX datapath reset |
| reqRx | input | 1 | Single-cycle pulse requesting an RX datapath reset |
| timeoutLimit | input | CNT_W | Maximum cycles allowed for any single wait |
| coreAckN | input | 1 | Low while the whole core is in reset |
| txAckN | input | 1 | Low while the TX datapath is in reset |
| rxAckN | input | 1 | Low while the RX datapath is in reset |
| txLanesStable | input | 1 | High when TX lanes are stable |
| rxPcsReady | input | 1 | High when the RX PCS is ready |
| coreRstN | output | 1 | Active-low full core reset request |
| txRstN | output | 1 | Active-low TX datapath reset request |
| rxRstN | output | 1 | Active-low RX datapath reset request |
| busy | output | 1 | A reset sequence is in progress |
| trafficReady | output | 1 | Core idle and both directions ready |
| timeoutErr | output | 1 | Sticky flag: a wait exceeded the limit |

## Verification
A behavioural core model answers each reset with programmable delays. The full reset is run with the TX acknowledge releasing first, then with the RX acknowledge releasing first, then with both releasing later than the core acknowledge. These three runs show whether the release logic depends on the order of the acknowledges. One run holds RX readiness back long after the core acknowledge returns. It separates leaving full reset from being ready for traffic. Request pulses arrive at the same time, queued behind a running sequence, and mixed with a full request. These patterns separate priority, latching and absorption. A responder that never acknowledges drives the timeout path and shows that the error flag is sticky.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FULL_ASSERT,
    ST_FULL_RELEASE,
    ST_FULL_READY,
    ST_TX_ASSERT,
    ST_TX_READY,
    ST_RX_ASSERT,
    ST_RX_READY
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeFull;
    logic takeTx;
    logic takeRx;
    logic cntClear;
    logic setErr;
  } seqStrobe_t;

  // synchronized observations of the core
  typedef struct packed {
    logic coreAckN;
    logic txAckN;
    logic rxAckN;
    logic txStable;
    logic rxReady;
  } seqObs_t;

  localparam int OBS_W = $bits(seqObs_t);
  // acknowledges idle high (not in reset), readiness idle low
  localparam logic [OBS_W-1:0] OBS_RST = 5'b11100;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic             reqFull,
  input  logic             reqTx,
  input  logic             reqRx,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             coreAckN,
  input  logic             txAckN,
  input  logic             rxAckN,
  input  logic             txLanesStable,
  input  logic             rxPcsReady,
  input  seqStrobe_t       strobe,
  output seqObs_t          obs,
  output logic             pendFull,
  output logic             pendTx,
  output logic             pendRx,
  output logic             expired,
  output logic             timeoutErr
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [OBS_W-1:0] rawObs;
  logic [OBS_W-1:0] syncObs;
  logic [CNT_W-1:0] waitCnt;

  assign rawObs = {coreAckN, txAckN, rxAckN, txLanesStable, rxPcsReady};

  rst_seq_sync #(
    .WIDTH  (OBS_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(OBS_RST)
  ) u_sync (
    .clk  (clk),
    .arstN(arstN),
    .din  (rawObs),
    .dout (syncObs)
  );

  assign obs = seqObs_t'(syncObs);

  // pending request latches; a new pulse wins over a same-cycle clear
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      pendFull <= 1'b0;
      pendTx   <= 1'b0;
      pendRx   <= 1'b0;
    end else begin
      pendFull <= (pendFull & ~strobe.takeFull) | reqFull;
      pendTx   <= (pendTx & ~(strobe.takeTx | strobe.takeFull)) | reqTx;
      pendRx   <= (pendRx & ~(strobe.takeRx | strobe.takeFull)) | reqRx;
    end
  end

  // bounded wait counter, saturating
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      waitCnt <= '0;
    end else if (strobe.cntClear) begin
      waitCnt <= '0;
    end else if (waitCnt != CNT_MAX) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  assign expired = (waitCnt >= timeoutLimit);

  // sticky error
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      timeoutErr <= 1'b0;
    end else if (strobe.setErr) begin
      timeoutErr <= 1'b1;
    end
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  seqObs_t    obs,
  input  logic       pendFull,
  input  logic       pendTx,
  input  logic       pendRx,
  input  logic       expired,
  output seqStrobe_t strobe,
  output logic       coreRstN,
  output logic       txRstN,
  output logic       rxRstN,
  output logic       busy,
  output logic       trafficReady
);

  seqState_t state;
  seqState_t nxt;
  seqStrobe_t strb;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_FULL_ASSERT;
    else        state <= nxt;
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      ST_IDLE: begin
        if (pendFull) begin
          nxt = ST_FULL_ASSERT;
          strb.takeFull = 1'b1;
        end else if (pendTx) begin
          nxt = ST_TX_ASSERT;
          strb.takeTx = 1'b1;
        end else if (pendRx) begin
          nxt = ST_RX_ASSERT;
          strb.takeRx = 1'b1;
        end
      end
      ST_FULL_ASSERT: begin
        if (!obs.coreAckN) nxt = ST_FULL_RELEASE;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      ST_FULL_RELEASE: begin
        if (obs.coreAckN) nxt = ST_FULL_READY;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      ST_FULL_READY: begin
        if (obs.txAckN && obs.rxAckN && obs.txStable && obs.rxReady) nxt = ST_IDLE;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      ST_TX_ASSERT: begin
        if (!obs.txAckN) nxt = ST_TX_READY;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      ST_TX_READY: begin
        if (obs.txAckN && obs.txStable) nxt = ST_IDLE;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      ST_RX_ASSERT: begin
        if (!obs.rxAckN) nxt = ST_RX_READY;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      ST_RX_READY: begin
        if (obs.rxAckN && obs.rxReady) nxt = ST_IDLE;
        else if (expired) begin
          nxt = ST_IDLE;
          strb.setErr = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    strb.cntClear = (nxt != state) || (state == ST_IDLE);
  end

  assign strobe       = strb;
  assign coreRstN     = (state != ST_FULL_ASSERT);
  assign txRstN       = (state != ST_TX_ASSERT);
  assign rxRstN       = (state != ST_RX_ASSERT);
  assign busy         = (state != ST_IDLE);
  assign trafficReady = (state == ST_IDLE) && obs.txStable && obs.rxReady;

endmodule

// File: rtl/reset_handshake_seq.sv
module reset_handshake_seq
  import rst_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic             reqFull,
  input  logic             reqTx,
  input  logic             reqRx,
  input  logic [CNT_W-1:0] timeoutLimit,
  input  logic             coreAckN,
  input  logic             txAckN,
  input  logic             rxAckN,
  input  logic             txLanesStable,
  input  logic             rxPcsReady,
  output logic             coreRstN,
  output logic             txRstN,
  output logic             rxRstN,
  output logic             busy,
  output logic             trafficReady,
  output logic             timeoutErr
);

  seqStrobe_t strobe;
  seqObs_t    obs;
  logic       pendFull;
  logic       pendTx;
  logic       pendRx;
  logic       expired;

  rst_seq_datapath #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .arstN        (arstN),
    .reqFull      (reqFull),
    .reqTx        (reqTx),
    .reqRx        (reqRx),
    .timeoutLimit (timeoutLimit),
    .coreAckN     (coreAckN),
    .txAckN       (txAckN),
    .rxAckN       (rxAckN),
    .txLanesStable(txLanesStable),
    .rxPcsReady   (rxPcsReady),
    .strobe       (strobe),
    .obs          (obs),
    .pendFull     (pendFull),
    .pendTx       (pendTx),
    .pendRx       (pendRx),
    .expired      (expired),
    .timeoutErr   (timeoutErr)
  );

  rst_seq_ctrl u_ctrl (
    .clk         (clk),
    .arstN       (arstN),
    .obs         (obs),
    .pendFull    (pendFull),
    .pendTx      (pendTx),
    .pendRx      (pendRx),
    .expired     (expired),
    .strobe      (strobe),
    .coreRstN    (coreRstN),
    .txRstN      (txRstN),
    .rxRstN      (rxRstN),
    .busy        (busy),
    .trafficReady(trafficReady)
  );

endmodule

// File: rtl/rst_seq_checker.sv
module rst_seq_checker (
  input logic clk,
  input logic arstN,
  input logic coreAckN,
  input logic txAckN,
  input logic rxAckN,
  input logic coreRstN,
  input logic txRstN,
  input logic rxRstN,
  input logic busy,
  input logic trafficReady,
  input logic timeoutErr
);

  a_r2_one_reset_low: assert property (@(posedge clk) disable iff (!arstN)
    $countones({~coreRstN, ~txRstN, ~rxRstN}) <= 1);

  a_r2_core_release_others_high: assert property (@(posedge clk) disable iff (!arstN)
    $rose(coreRstN) |-> (txRstN && rxRstN));

  a_r3_core_after_ack: assert property (@(posedge clk) disable iff (!arstN)
    $rose(coreRstN) |-> (!$past(coreAckN, 3) || timeoutErr));

  a_r3_tx_after_ack: assert property (@(posedge clk) disable iff (!arstN)
    $rose(txRstN) |-> (!$past(txAckN, 3) || timeoutErr));

  a_r3_rx_after_ack: assert property (@(posedge clk) disable iff (!arstN)
    $rose(rxRstN) |-> (!$past(rxAckN, 3) || timeoutErr));

  a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!arstN)
    trafficReady |-> (!busy && coreRstN && txRstN && rxRstN));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!arstN)
    timeoutErr |=> timeoutErr);

  a_r11_err_releases: assert property (@(posedge clk) disable iff (!arstN)
    $rose(timeoutErr) |-> (coreRstN && txRstN && rxRstN));

  a_r12_busy_during_reset: assert property (@(posedge clk) disable iff (!arstN)
    (!coreRstN || !txRstN || !rxRstN) |-> busy);

endmodule

bind reset_handshake_seq rst_seq_checker u_chk (
  .clk         (clk),
  .arstN       (arstN),
  .coreAckN    (coreAckN),
  .txAckN      (txAckN),
  .rxAckN      (rxAckN),
  .coreRstN    (coreRstN),
  .txRstN      (txRstN),
  .rxRstN      (rxRstN),
  .busy        (busy),
  .trafficReady(trafficReady),
  .timeoutErr  (timeoutErr)
);

// File: tb/reset_handshake_seq_test.sv
module reset_handshake_seq_test;
  localparam int CW = 16;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic arstN = 1'b0;
  logic reqFull = 1'b0, reqTx = 1'b0, reqRx = 1'b0;
  logic [CW-1:0] timeoutLimit = 16'd200;
  logic coreAckN = 1'b0, txAckN = 1'b0, rxAckN = 1'b0;
  logic txLanesStable = 1'b0, rxPcsReady = 1'b0;
  logic coreRstN, txRstN, rxRstN, busy, trafficReady, timeoutErr;

  // responder knobs
  int coreRelDly = 3, txRelDly = 5, rxRelDly = 7;
  bit stuckTx = 1'b0;
  int coreAs = 0, coreRel = 0, txAs = 0, txRel = 0, rxAs = 0, rxRel = 0;

  reset_handshake_seq #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .arstN(arstN), .reqFull(reqFull), .reqTx(reqTx), .reqRx(reqRx),
    .timeoutLimit(timeoutLimit), .coreAckN(coreAckN), .txAckN(txAckN), .rxAckN(rxAckN),
    .txLanesStable(txLanesStable), .rxPcsReady(rxPcsReady), .coreRstN(coreRstN),
    .txRstN(txRstN), .rxRstN(rxRstN), .busy(busy), .trafficReady(trafficReady),
    .timeoutErr(timeoutErr)
  );

  // behavioural core model
  always @(posedge clk) begin
    if (!coreRstN) begin
      coreRel <= 0;
      if (coreAs < 1000) coreAs <= coreAs + 1;
      if (coreAs >= 2) coreAckN <= 1'b0;
    end else begin
      coreAs <= 0;
      if (coreRel < 1000) coreRel <= coreRel + 1;
      if (coreRel >= coreRelDly) coreAckN <= 1'b1;
    end
    if (!coreRstN || !txRstN) begin
      txRel <= 0;
      txLanesStable <= 1'b0;
      if (txAs < 1000) txAs <= txAs + 1;
      if (txAs >= 2 && !stuckTx) txAckN <= 1'b0;
    end else begin
      txAs <= 0;
      if (txRel < 1000) txRel <= txRel + 1;
      if (txRel >= txRelDly) txAckN <= 1'b1;
      if (txRel >= txRelDly + 2) txLanesStable <= 1'b1;
    end
    if (!coreRstN || !rxRstN) begin
      rxRel <= 0;
      rxPcsReady <= 1'b0;
      if (rxAs < 1000) rxAs <= rxAs + 1;
      if (rxAs >= 2) rxAckN <= 1'b0;
    end else begin
      rxAs <= 0;
      if (rxRel < 1000) rxRel <= rxRel + 1;
      if (rxRel >= rxRelDly) rxAckN <= 1'b1;
      if (rxRel >= rxRelDly + 2) rxPcsReady <= 1'b1;
    end
  end

  // bookkeeping monitor
  int nChecks = 0, nFails = 0, cyc = 0;
  int coreFalls = 0, txFalls = 0, rxFalls = 0;
  int txFallCyc = 0, txRiseCyc = 0, rxFallCyc = 0;
  int txAckRun = 0, rxAckRun = 0, coreAckRun = 0;
  int ackViol = 0, multiLow = 0;
  logic pCore = 1'b0, pTx = 1'b1, pRx = 1'b1;
  bit done = 1'b0;

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (arstN) begin
      if (!coreRstN && pCore) begin coreFalls <= coreFalls + 1; end
      if (!txRstN && pTx) begin txFalls <= txFalls + 1; txFallCyc <= cyc; end
      if (txRstN && !pTx) begin
        txRiseCyc <= cyc;
        if (txAckRun < 2 && !timeoutErr) ackViol <= ackViol + 1;
      end
      if (!rxRstN && pRx) begin rxFalls <= rxFalls + 1; rxFallCyc <= cyc; end
      if (rxRstN && !pRx && rxAckRun < 2 && !timeoutErr) ackViol <= ackViol + 1;
      if (coreRstN && !pCore && coreAckRun < 2 && !timeoutErr) ackViol <= ackViol + 1;
      if ((!coreRstN + !txRstN + !rxRstN) > 1) multiLow <= multiLow + 1;
    end
    txAckRun   <= txAckN ? 0 : txAckRun + 1;
    rxAckRun   <= rxAckN ? 0 : rxAckRun + 1;
    coreAckRun <= coreAckN ? 0 : coreAckRun + 1;
    pCore <= coreRstN; pTx <= txRstN; pRx <= rxRstN;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic pulse(input bit f, input bit t, input bit r);
    @(negedge clk);
    reqFull = f; reqTx = t; reqRx = r;
    @(negedge clk);
    reqFull = 1'b0; reqTx = 1'b0; reqRx = 1'b0;
  endtask

  task automatic waitIdle(input int maxCyc, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (busy && n < maxCyc);
  endtask

  task automatic tPowerOn();
    int n;
    repeat (3) @(negedge clk);
    checkEq("R1 core low in reset", coreRstN, 0);
    checkEq("R1 tx high in reset", txRstN, 1);
    checkEq("R1 rx high in reset", rxRstN, 1);
    checkEq("R1 busy in reset", busy, 1);
    arstN = 1'b1;
    @(negedge clk);
    checkEq("R1 core still low after reset", coreRstN, 0);
    waitIdle(300, n);
    checkEq("R1 power-on sequence finished", busy, 0);
    checkEq("R1 core released", coreRstN, 1);
    checkEq("R7 ready after power-on", trafficReady, 1);
    checkEq("R11 no error at power-on", timeoutErr, 0);
  endtask

  task automatic tTxReset();
    int n, tf = txFalls, rf = rxFalls, cf = coreFalls;
    pulse(0, 1, 0);
    @(negedge clk);
    checkEq("R12 tx taken after two edges", txRstN, 0);
    checkEq("R12 busy with tx", busy, 1);
    checkEq("R4 core untouched", coreRstN, 1);
    checkEq("R4 rx untouched", rxRstN, 1);
    waitIdle(300, n);
    checkEq("R4 one tx reset", txFalls - tf, 1);
    checkEq("R4 no rx or core reset", (rxFalls - rf) + (coreFalls - cf), 0);
    checkEq("R4 lanes stable at end", txLanesStable, 1);
    @(negedge clk);
    @(negedge clk);
    checkEq("R7 ready after tx", trafficReady, 1);
  endtask

  task automatic tRxReset();
    int n, tf = txFalls, rf = rxFalls;
    pulse(0, 0, 1);
    @(negedge clk);
    checkEq("R5 rx taken", rxRstN, 0);
    checkEq("R5 tx untouched", txRstN, 1);
    checkEq("R7 not ready while rx reset", trafficReady, 0);
    waitIdle(300, n);
    checkEq("R5 one rx reset", rxFalls - rf, 1);
    checkEq("R5 no tx reset", txFalls - tf, 0);
    checkEq("R5 pcs ready at end", rxPcsReady, 1);
  endtask

  task automatic tFull(input int cd, input int td, input int rd, input string tag);
    int n, tf = txFalls, rf = rxFalls, cf = coreFalls;
    coreRelDly = cd; txRelDly = td; rxRelDly = rd;
    pulse(1, 0, 0);
    @(negedge clk);
    checkEq({"R2 core low only ", tag}, {coreRstN, txRstN, rxRstN}, 3'b011);
    waitIdle(400, n);
    checkEq({"R6 sequence ends ", tag}, busy, 0);
    checkEq({"R6 one core reset ", tag}, coreFalls - cf, 1);
    checkEq({"R6 no partial resets ", tag}, (txFalls - tf) + (rxFalls - rf), 0);
    checkEq({"R6 both ready ", tag}, {txLanesStable, rxPcsReady}, 2'b11);
    @(negedge clk);
    @(negedge clk);
    checkEq({"R7 ready ", tag}, trafficReady, 1);
  endtask

  task automatic tReadyGate();
    int n;
    coreRelDly = 2; txRelDly = 3; rxRelDly = 40;
    pulse(1, 0, 0);
    while (!(coreRstN && coreAckN)) @(negedge clk);
    repeat (6) @(negedge clk);
    checkEq("R7 core out but rx not ready: busy", busy, 1);
    checkEq("R7 core out but rx not ready: no ready", trafficReady, 0);
    waitIdle(400, n);
    @(negedge clk);
    @(negedge clk);
    checkEq("R7 ready after rx ready", trafficReady, 1);
    rxRelDly = 7;
  endtask

  task automatic tPriority();
    int n, tf = txFalls, rf = rxFalls, cf = coreFalls;
    pulse(0, 1, 1);
    waitIdle(300, n);
    waitIdle(300, n);
    checkEq("R8 both served", (txFalls - tf) + (rxFalls - rf), 2);
    checkEq("R8 tx before rx", (txFallCyc < rxFallCyc) ? 1 : 0, 1);
    tf = txFalls; rf = rxFalls;
    pulse(1, 1, 1);
    waitIdle(400, n);
    repeat (4) @(negedge clk);
    checkEq("R8 full taken first", coreFalls - cf, 1);
    checkEq("R10 partial requests absorbed", (txFalls - tf) + (rxFalls - rf), 0);
    checkEq("R10 idle after absorb", busy, 0);
  endtask

  task automatic tQueue();
    int n, tf = txFalls, rf = rxFalls, cf = coreFalls;
    pulse(0, 1, 0);
    repeat (3) @(negedge clk);
    pulse(0, 0, 1);
    waitIdle(300, n);
    waitIdle(300, n);
    checkEq("R9 queued rx served", rxFalls - rf, 1);
    checkEq("R9 rx after tx released", (rxFallCyc > txRiseCyc) ? 1 : 0, 1);
    tf = txFalls; rf = rxFalls;
    pulse(0, 1, 0);
    repeat (3) @(negedge clk);
    pulse(0, 0, 1);
    pulse(1, 0, 0);
    waitIdle(300, n);
    waitIdle(400, n);
    repeat (4) @(negedge clk);
    checkEq("R10 queued full served", coreFalls - cf, 1);
    checkEq("R10 queued rx absorbed", rxFalls - rf, 0);
    checkEq("R10 tx ran once", txFalls - tf, 1);
  endtask

  task automatic tTimeout();
    int n;
    checkEq("R3 acks respected before timeout", ackViol, 0);
    timeoutLimit = 16'd20;
    stuckTx = 1'b1;
    pulse(0, 1, 0);
    repeat (10) begin @(negedge clk); end
    checkEq("R11 no error mid-wait", timeoutErr, 0);
    checkEq("R11 tx still held", txRstN, 0);
    waitIdle(100, n);
    n = n + 10;
    checkEq("R11 expiry window", (n >= 18 && n <= 28) ? 1 : 0, 1);
    checkEq("R11 error set", timeoutErr, 1);
    checkEq("R11 tx released on expiry", txRstN, 1);
    checkEq("R11 idle after expiry", busy, 0);
    stuckTx = 1'b0;
    timeoutLimit = 16'd200;
    pulse(0, 1, 0);
    waitIdle(300, n);
    repeat (3) @(negedge clk);
    checkEq("R11 error sticky", timeoutErr, 1);
    checkEq("R4 recovers after timeout", trafficReady, 1);
  endtask

  initial begin
    tPowerOn();
    tTxReset();
    tRxReset();
    tFull(4, 1, 8, "tx first");
    tFull(4, 8, 1, "rx first");
    tFull(2, 6, 6, "acks after core");
    tReadyGate();
    tPriority();
    tQueue();
    tTimeout();
    checkEq("R2 never two resets low", multiLow, 0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule